// File: doc/BRIEF.md
# Receive Packet DMA Copy Engine

This block drains received packets from a packet FIFO into host memory, one host-sized chunk at a time. Software arms it by writing a receive descriptor that carries a host address and the largest number of bytes it is willing to accept. The engine then takes the packet at the head of the FIFO, or resumes the packet it is already working on. It requests the shared DMA port and issues one write for `min(descriptor length, bytes left in packet)`. When the write completes, it publishes a done word and raises a one-cycle interrupt. A packet longer than the descriptor is split into several chunks. Between chunks the engine keeps a residual byte offset into the packet and a remaining-byte count, and it marks every chunk but the last with a More bit.

Protocol and checksum-error flags come from a separate parser. They are captured when a packet is taken from the FIFO and are reported with every chunk of that packet. The DMA port is shared with a transmit engine. This engine never requests while the port is busy, and it defers while the transmit engine is waiting to start its own copy. For each chunk it also drives a modelled completion cost: a fixed delay plus one per-block factor for every started 64-byte block.

The state machine has five states: IDLE, FIFO_BLOCK, BEGIN_COPY, COPY and COPY_DONE. Its transitions are:
- IDLE→FIFO_BLOCK: a descriptor is written.
- FIFO_BLOCK→BEGIN_COPY: a packet is already in progress, or the FIFO holds at least one packet.
- BEGIN_COPY→COPY: the request is granted.
- COPY→COPY_DONE: the DMA reports done.
- COPY_DONE→IDLE: always, after one cycle.

Top module: `rxdma_copy_engine`

## Requirements
- R1: After reset the engine is idle: `dma_req`, `irq_rx_dma`, `fifo_pop` and `desc_err` are 0, and `done_word` holds only the packet-count field.
- R2: A descriptor written in IDLE is accepted. From the next cycle `done_word` shows only the Busy bit (bit 24) and the count field, and the engine waits in FIFO_BLOCK.
- R3: A descriptor written in any state other than IDLE raises `desc_err` for exactly one cycle and is discarded: the chunk in progress keeps the first descriptor's address and length.
- R4: In FIFO_BLOCK with no packet in progress and `fifo_count` = 0, `dma_req` stays 0.
- R5: While requesting, `dma_len` = min(descriptor length, remaining bytes), `dma_addr` = descriptor address, and `dma_off` = byte offset of the chunk within the packet (0 for a first chunk).
- R6: `dma_cost` = DMA_DELAY + ceil(`dma_len`/64) × BLOCK_FACTOR.
- R7: In BEGIN_COPY, `dma_req` is 0 while `dma_busy` or `tx_waiting` is 1, and the engine stays in BEGIN_COPY until it is granted.
- R8: A chunk that leaves bytes in the packet publishes `done_word` = length [15:0] | flags [21:16] | More (bit 22) | Complete (bit 23). It does not pop the FIFO. The next descriptor continues at the advanced offset without a new FIFO take.
- R9: The last chunk of a packet pulses `fifo_pop` for one cycle in COPY_DONE and publishes the done word with More clear and Complete set.
- R10: `irq_rx_dma` pulses for exactly one cycle per completed chunk, in COPY_DONE.
- R11: Flags are taken from `fifo_head_flags` when a packet is taken and are held for all its chunks. Flag bit order: 0 IP, 1 IP checksum error, 2 TCP, 3 TCP checksum error, 4 UDP, 5 UDP checksum error.
- R12: `done_word` [31:25] always shows the live `fifo_count`, saturated at 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_wr | input | 1 | Descriptor write strobe |
| desc_addr | input | ADDR_W | Host address for the chunk |
| desc_len | input | LEN_W | Largest chunk the host accepts |
| desc_err | output | 1 | One-cycle pulse: descriptor written while not idle |
| fifo_count | input | FCNT_W | Packets held in the receive FIFO |
| fifo_head_len | input | LEN_W | Byte length of the head packet |
| fifo_head_flags | input | 6 | Parser flags of the head packet |
| fifo_pop | output | 1 | Remove the head packet |
| tx_waiting | input | 1 | Transmit engine waits to start its copy |
| dma_busy | input | 1 | Shared DMA port occupied |
| dma_req | output | 1 | DMA write request |
| dma_gnt | input | 1 | DMA request granted |
| dma_done | input | 1 | DMA write finished |
| dma_addr | output | ADDR_W | Host address of the write |
| dma_off | output | LEN_W | Byte offset of the chunk in the packet |
| dma_len | output | LEN_W | Chunk length |
| dma_cost | output | COST_W | Modelled completion cycles of the write |
| done_word | output | 32 | Published chunk result and FIFO packet count |
| irq_rx_dma | output | 1 | One-cycle chunk-done interrupt |

## Verification
A wrong remaining count or offset shows up as a wrong `dma_len` or `dma_off` at the very next request, and as a `fifo_pop` that comes one chunk early or late. A stuck or skipped state shows up as a missing `irq_rx_dma` pulse, or as a request raised while the port is busy or the transmit engine waits, within one cycle of the fault. Flags latched at the wrong moment show up in `done_word` [21:16] on the following chunk, because the bench scrambles the head flags once a packet has been taken.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    typedef enum logic [2:0] {
        RX_IDLE       = 3'd0,
        RX_FIFO_BLOCK = 3'd1,
        RX_BEGIN_COPY = 3'd2,
        RX_COPY       = 3'd3,
        RX_COPY_DONE  = 3'd4
    } rx_state_e;

    localparam int FLAG_W = 6;

    localparam int FL_IP      = 0;
    localparam int FL_IP_ERR  = 1;
    localparam int FL_TCP     = 2;
    localparam int FL_TCP_ERR = 3;
    localparam int FL_UDP     = 4;
    localparam int FL_UDP_ERR = 5;

endpackage

// File: rtl/rxdma_chunk_calc.sv
module rxdma_chunk_calc #(
    parameter int LEN_W        = 16,
    parameter int COST_W       = 24,
    parameter int DMA_DELAY    = 8,
    parameter int BLOCK_FACTOR = 3,
    parameter int BLOCK_SHIFT  = 6
) (
    input  logic [LEN_W-1:0]  desc_len,
    input  logic [LEN_W-1:0]  remain,
    output logic [LEN_W-1:0]  chunk_len,
    output logic [COST_W-1:0] cost
);
    localparam int BLK_MASK = (1 << BLOCK_SHIFT) - 1;

    logic [LEN_W:0] rounded;
    logic [LEN_W:0] blocks;

    always_comb begin
        chunk_len = (desc_len < remain) ? desc_len : remain;
        rounded   = {1'b0, chunk_len} + (LEN_W+1)'(BLK_MASK);
        blocks    = rounded >> BLOCK_SHIFT;
        cost      = COST_W'(DMA_DELAY) + COST_W'(blocks) * COST_W'(BLOCK_FACTOR);
    end

endmodule

// File: rtl/rxdma_port_gate.sv
module rxdma_port_gate (
    input  logic in_begin,
    input  logic dma_busy,
    input  logic tx_waiting,
    output logic req
);
    // Transmit side is served first whenever it is waiting to start.
    always_comb begin
        req = in_begin && !dma_busy && !tx_waiting;
    end

endmodule

// File: rtl/rxdma_done_fmt.sv
module rxdma_done_fmt #(
    parameter int LEN_W  = 16,
    parameter int FLAG_W = 6,
    parameter int CNT_W  = 7,
    parameter int FCNT_W = 8,
    localparam int WORD_W = LEN_W + FLAG_W + 3 + CNT_W
) (
    input  logic [LEN_W-1:0]  len,
    input  logic [FLAG_W-1:0] flags,
    input  logic              more,
    input  logic              complete,
    input  logic              busy,
    input  logic [FCNT_W-1:0] fifo_count,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic [CNT_W-1:0] cnt_field;

    generate
        if (FCNT_W > CNT_W) begin : g_sat
            always_comb begin
                if (fifo_count > FCNT_W'(CNT_MAX))
                    cnt_field = CNT_W'(CNT_MAX);
                else
                    cnt_field = fifo_count[CNT_W-1:0];
            end
        end else begin : g_ext
            always_comb begin
                cnt_field = CNT_W'(fifo_count);
            end
        end
    endgenerate

    always_comb begin
        word = {cnt_field, busy, complete, more, flags, len};
    end

endmodule

// File: rtl/rxdma_copy_engine.sv
module rxdma_copy_engine
    import rxdma_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int LEN_W        = 16,
    parameter int FCNT_W       = 8,
    parameter int CNT_W        = 7,
    parameter int COST_W       = 24,
    parameter int DMA_DELAY    = 8,
    parameter int BLOCK_FACTOR = 3,
    parameter int BLOCK_SHIFT  = 6,
    localparam int DONE_W      = LEN_W + FLAG_W + 3 + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_wr,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [LEN_W-1:0]  desc_len,
    output logic              desc_err,
    input  logic [FCNT_W-1:0] fifo_count,
    input  logic [LEN_W-1:0]  fifo_head_len,
    input  logic [FLAG_W-1:0] fifo_head_flags,
    output logic              fifo_pop,
    input  logic              tx_waiting,
    input  logic              dma_busy,
    output logic              dma_req,
    input  logic              dma_gnt,
    input  logic              dma_done,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [LEN_W-1:0]  dma_off,
    output logic [LEN_W-1:0]  dma_len,
    output logic [COST_W-1:0] dma_cost,
    output logic [DONE_W-1:0] done_word,
    output logic              irq_rx_dma
);

    rx_state_e state, state_nx;

    logic [ADDR_W-1:0] desc_addr_q;
    logic [LEN_W-1:0]  desc_len_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  off_q;
    logic [LEN_W-1:0]  chunk_q;
    logic [FLAG_W-1:0] flags_q;
    logic              in_pkt_q;
    logic              desc_err_q;

    logic [LEN_W-1:0]  done_len_q;
    logic [FLAG_W-1:0] done_flags_q;
    logic              done_more_q;
    logic              done_cmpl_q;
    logic              done_busy_q;

    logic [LEN_W-1:0]  chunk_len;
    logic [COST_W-1:0] chunk_cost;
    logic              gate_req;
    logic              take_pkt;
    logic              last_chunk;

    rxdma_chunk_calc #(
        .LEN_W       (LEN_W),
        .COST_W      (COST_W),
        .DMA_DELAY   (DMA_DELAY),
        .BLOCK_FACTOR(BLOCK_FACTOR),
        .BLOCK_SHIFT (BLOCK_SHIFT)
    ) u_calc (
        .desc_len (desc_len_q),
        .remain   (rem_q),
        .chunk_len(chunk_len),
        .cost     (chunk_cost)
    );

    rxdma_port_gate u_gate (
        .in_begin  (state == RX_BEGIN_COPY),
        .dma_busy  (dma_busy),
        .tx_waiting(tx_waiting),
        .req       (gate_req)
    );

    rxdma_done_fmt #(
        .LEN_W (LEN_W),
        .FLAG_W(FLAG_W),
        .CNT_W (CNT_W),
        .FCNT_W(FCNT_W)
    ) u_fmt (
        .len       (done_len_q),
        .flags     (done_flags_q),
        .more      (done_more_q),
        .complete  (done_cmpl_q),
        .busy      (done_busy_q),
        .fifo_count(fifo_count),
        .word      (done_word)
    );

    assign take_pkt   = (state == RX_FIFO_BLOCK) && !in_pkt_q && (fifo_count != '0);
    assign last_chunk = (rem_q == chunk_q);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:       if (desc_wr) state_nx = RX_FIFO_BLOCK;
            RX_FIFO_BLOCK: if (in_pkt_q || fifo_count != '0) state_nx = RX_BEGIN_COPY;
            RX_BEGIN_COPY: if (gate_req && dma_gnt) state_nx = RX_COPY;
            RX_COPY:       if (dma_done) state_nx = RX_COPY_DONE;
            RX_COPY_DONE:  state_nx = RX_IDLE;
            default:       state_nx = RX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    // Outputs
    always_comb begin
        dma_req    = gate_req;
        dma_addr   = desc_addr_q;
        dma_off    = off_q;
        dma_len    = chunk_len;
        dma_cost   = chunk_cost;
        irq_rx_dma = (state == RX_COPY_DONE);
        fifo_pop   = (state == RX_COPY_DONE) && last_chunk;
        desc_err   = desc_err_q;
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_addr_q  <= '0;
            desc_len_q   <= '0;
            rem_q        <= '0;
            off_q        <= '0;
            chunk_q      <= '0;
            flags_q      <= '0;
            in_pkt_q     <= 1'b0;
            desc_err_q   <= 1'b0;
            done_len_q   <= '0;
            done_flags_q <= '0;
            done_more_q  <= 1'b0;
            done_cmpl_q  <= 1'b0;
            done_busy_q  <= 1'b0;
        end else begin
            desc_err_q <= desc_wr && (state != RX_IDLE);

            if (state == RX_IDLE && desc_wr) begin
                desc_addr_q  <= desc_addr;
                desc_len_q   <= desc_len;
                done_len_q   <= '0;
                done_flags_q <= '0;
                done_more_q  <= 1'b0;
                done_cmpl_q  <= 1'b0;
                done_busy_q  <= 1'b1;
            end

            if (take_pkt) begin
                rem_q    <= fifo_head_len;
                off_q    <= '0;
                flags_q  <= fifo_head_flags;
                in_pkt_q <= 1'b1;
            end

            if (state == RX_BEGIN_COPY && gate_req && dma_gnt)
                chunk_q <= chunk_len;

            if (state == RX_COPY_DONE) begin
                done_len_q   <= chunk_q;
                done_flags_q <= flags_q;
                done_cmpl_q  <= 1'b1;
                done_busy_q  <= 1'b0;
                if (last_chunk) begin
                    done_more_q <= 1'b0;
                    in_pkt_q    <= 1'b0;
                end else begin
                    done_more_q <= 1'b1;
                    off_q       <= off_q + chunk_q;
                    rem_q       <= rem_q - chunk_q;
                end
            end
        end
    end

    // Assertions
    p_ignore_desc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != RX_IDLE && desc_wr) |=> (desc_err && $stable(desc_len_q) && $stable(desc_addr_q)));

    p_wait_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_FIFO_BLOCK && !in_pkt_q && fifo_count == '0) |=> (state == RX_FIFO_BLOCK));

    p_chunk_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (dma_len <= rem_q && dma_len <= desc_len_q));

    p_hold_begin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_BEGIN_COPY && (dma_busy || tx_waiting)) |=> (state == RX_BEGIN_COPY));

    p_pop_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> (state == RX_IDLE && !in_pkt_q && !done_more_q));

    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_dma |=> (!irq_rx_dma && done_cmpl_q));

    p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pkt_q && $past(in_pkt_q)) |-> $stable(flags_q));

endmodule

// File: tb/rxdma_copy_engine_test.sv
module rxdma_copy_engine_test;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int FCNT_W = 8;
    localparam int COST_W = 24;
    localparam int DLY    = 8;
    localparam int FAC    = 3;
    localparam int NVEC   = 6;

    // {packet length, descriptor length, flags}
    localparam int VEC [NVEC][3] = '{
        '{100, 256, 6'b000001},
        '{300, 128, 6'b000101},
        '{64,  64,  6'b010011},
        '{65,  64,  6'b110001},
        '{200, 200, 6'b000000},
        '{130, 1,   6'b001100}
    };

    logic              clk = 0;
    logic              rst_n = 0;
    logic              desc_wr = 0;
    logic [ADDR_W-1:0] desc_addr = '0;
    logic [LEN_W-1:0]  desc_len = '0;
    logic              desc_err;
    logic [FCNT_W-1:0] fifo_count = '0;
    logic [LEN_W-1:0]  fifo_head_len = '0;
    logic [5:0]        fifo_head_flags = '0;
    logic              fifo_pop;
    logic              tx_waiting = 0;
    logic              dma_busy = 0;
    logic              dma_req;
    logic              dma_gnt = 0;
    logic              dma_done = 0;
    logic [ADDR_W-1:0] dma_addr;
    logic [LEN_W-1:0]  dma_off;
    logic [LEN_W-1:0]  dma_len;
    logic [COST_W-1:0] dma_cost;
    logic [31:0]       done_word;
    logic              irq_rx_dma;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rxdma_copy_engine #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FCNT_W(FCNT_W), .CNT_W(7),
        .COST_W(COST_W), .DMA_DELAY(DLY), .BLOCK_FACTOR(FAC), .BLOCK_SHIFT(6)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .desc_wr(desc_wr), .desc_addr(desc_addr), .desc_len(desc_len), .desc_err(desc_err),
        .fifo_count(fifo_count), .fifo_head_len(fifo_head_len),
        .fifo_head_flags(fifo_head_flags), .fifo_pop(fifo_pop),
        .tx_waiting(tx_waiting), .dma_busy(dma_busy),
        .dma_req(dma_req), .dma_gnt(dma_gnt), .dma_done(dma_done),
        .dma_addr(dma_addr), .dma_off(dma_off), .dma_len(dma_len), .dma_cost(dma_cost),
        .done_word(done_word), .irq_rx_dma(irq_rx_dma)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic longint exp_done(int len, int fl, bit more, bit cmpl, bit busy, int cnt);
        int c;
        c = (cnt > 127) ? 127 : cnt;
        return (longint'(c) << 25) | (longint'(busy) << 24) | (longint'(cmpl) << 23) |
               (longint'(more) << 22) | (longint'(fl) << 16) | longint'(len);
    endfunction

    function automatic int exp_cost(int len);
        return DLY + ((len + 63) / 64) * FAC;
    endfunction

    task automatic write_desc(input int addr, input int len);
        @(negedge clk);
        desc_wr   = 1;
        desc_addr = ADDR_W'(addr);
        desc_len  = LEN_W'(len);
        @(negedge clk);
        desc_wr = 0;
    endtask

    task automatic wait_req();
        for (int k = 0; k < 50 && !dma_req; k++) @(negedge clk);
        chk(dma_req == 1, "R5 request raised", dma_req, 1);
    endtask

    // Called at a negedge with dma_req high; ends at the negedge after COPY_DONE.
    task automatic run_copy(input int len, input int fl, input bit last, output bit popped);
        dma_gnt = 1;
        @(negedge clk);
        dma_gnt = 0;
        repeat (3) @(negedge clk);
        dma_done = 1;
        @(negedge clk);
        dma_done = 0;
        chk(irq_rx_dma == 1, "R10 irq in copy-done", irq_rx_dma, 1);
        chk(fifo_pop == last, "R9 pop on last chunk only", fifo_pop, last);
        popped = fifo_pop;
        if (fifo_pop) fifo_count = fifo_count - 1;
        @(negedge clk);
        chk(irq_rx_dma == 0, "R10 irq single cycle", irq_rx_dma, 0);
        chk(done_word == 32'(exp_done(len, fl, !last, 1, 0, int'(fifo_count))),
            last ? "R9 done word last" : "R8 done word more",
            done_word, exp_done(len, fl, !last, 1, 0, int'(fifo_count)));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit popped;
        fifo_count = 3;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state, R12 count field
        chk(dma_req == 0 && irq_rx_dma == 0 && fifo_pop == 0 && desc_err == 0,
            "R1 idle outputs", {dma_req, irq_rx_dma, fifo_pop, desc_err}, 0);
        chk(done_word == 32'(exp_done(0, 0, 0, 0, 0, 3)), "R1 R12 reset done word",
            done_word, exp_done(0, 0, 0, 0, 0, 3));

        // Table-driven packets
        for (int i = 0; i < NVEC; i++) begin
            int remaining;
            int off;
            int k;
            remaining       = VEC[i][0];
            off             = 0;
            k               = 0;
            fifo_count      = FCNT_W'(i + 1);
            fifo_head_len   = LEN_W'(VEC[i][0]);
            fifo_head_flags = 6'(VEC[i][2]);
            while (remaining > 0) begin
                int chunk;
                int addr;
                bit last;
                chunk = (VEC[i][1] < remaining) ? VEC[i][1] : remaining;
                addr  = 32'h1000 + i * 32'h1000 + k * 32'h100;
                last  = (chunk == remaining);
                write_desc(addr, VEC[i][1]);
                chk(done_word == 32'(exp_done(0, 0, 0, 0, 1, int'(fifo_count))), "R2 busy word",
                    done_word, exp_done(0, 0, 0, 0, 1, int'(fifo_count)));
                wait_req();
                chk(int'(dma_len) == chunk, "R5 chunk length", dma_len, chunk);
                chk(int'(dma_off) == off, "R8 residual offset", dma_off, off);
                chk(int'(dma_addr) == addr, "R5 host address", dma_addr, addr);
                chk(int'(dma_cost) == exp_cost(chunk), "R6 cost", dma_cost, exp_cost(chunk));
                fifo_head_flags = ~6'(VEC[i][2]);  // R11: must not leak into this packet
                run_copy(chunk, VEC[i][2], last, popped);
                remaining -= chunk;
                off       += chunk;
                k++;
            end
        end

        // R4 and R3: empty FIFO, then a second descriptor while waiting
        fifo_count      = 0;
        fifo_head_len   = 80;
        fifo_head_flags = 6'b000011;
        write_desc(32'h4000, 50);
        for (int j = 0; j < 5; j++) begin
            chk(dma_req == 0, "R4 no request on empty fifo", dma_req, 0);
            @(negedge clk);
        end
        write_desc(32'h8000, 20);
        chk(desc_err == 1, "R3 error pulse", desc_err, 1);
        @(negedge clk);
        chk(desc_err == 0, "R3 error single cycle", desc_err, 0);

        // R7: hold requests while the port is busy or transmit waits
        dma_busy   = 1;
        fifo_count = 1;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(dma_req == 0, "R7 yield to busy port", dma_req, 0);
        end
        dma_busy   = 0;
        tx_waiting = 1;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(dma_req == 0, "R7 yield to transmit", dma_req, 0);
        end
        tx_waiting = 0;
        @(negedge clk);
        chk(dma_req == 1, "R7 request after release", dma_req, 1);
        chk(int'(dma_addr) == 32'h4000, "R3 first descriptor address kept", dma_addr, 32'h4000);
        chk(int'(dma_len) == 50, "R3 first descriptor length kept", dma_len, 50);
        run_copy(50, 3, 0, popped);

        // R8 continuation, R12 saturation
        fifo_count = 200;
        write_desc(32'h9000, 64);
        wait_req();
        chk(int'(dma_off) == 50 && int'(dma_len) == 30, "R8 continuation offset/len",
            {dma_off, dma_len}, {16'd50, 16'd30});
        chk(done_word[31:25] == 7'd127, "R12 count saturates", done_word[31:25], 127);
        run_copy(30, 3, 1, popped);
        chk(popped == 1, "R9 popped after continuation", popped, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule